// File: doc/BRIEF.md
# Service-Request Priority Scheduler

This block chooses which pending service request an embedded communications controller handles next. Fifteen request lines come in, one for each source. They cover a reset request, a system-bus error, a host command, two DMA request channels, and separate receive and transmit requests for a USB port, two serial communication controllers (A and B) and two serial management controllers (A and B). When the scheduler is idle, it picks the single highest-ranked pending request. It registers the result as a one-hot grant, a valid flag and a rank index, and holds that grant until the controller pulses `done_i`.

Each DMA channel has its own mode bit. The bit places that channel either just below the host command, above all serial traffic, or in a low slot below the fast serial controllers and above the management controllers. The mode bits only take effect when the scheduler picks a new winner. A grant that is already outstanding is never reordered by them. A reset request is the one exception to holding a grant: it takes over any outstanding grant.

Top module: `svc_req_sched`

## Requirements
- R1: During and directly after reset, `gnt_valid_o` is 0, `gnt_o` is all zeros and `gnt_idx_o` is 0.
- R2: A reset request (`req_i[0]`) wins over every other request and is granted with index 0.
- R3: A bus-error request (`req_i[1]`, index 1) wins over the host command (`req_i[2]`, index 2) and over all data-transfer requests.
- R4: With both mode bits 0, the ranks are as follows:
  - host command 2
  - DMA1 (`req_i[3]`) 3 and DMA2 (`req_i[4]`) 4
  - USB rx/tx (`req_i[5]`/`req_i[6]`) 5/6
  - SCC-A rx/tx (`req_i[7]`/`[8]`) 7/8
  - SCC-B rx/tx (`[9]`/`[10]`) 9/10
  - SMC-A rx/tx (`[11]`/`[12]`) 13/14
  - SMC-B rx/tx (`[13]`/`[14]`) 15/16
- R5: Setting `dma_low_i[0]` moves DMA1 to rank 11. Setting `dma_low_i[1]` moves DMA2 to rank 12. Both low slots lie below SCC-B transmit and above SMC-A receive.
- R6: For every serial controller, the receive request ranks exactly one above its transmit request.
- R7: While a grant is outstanding, `gnt_o` and `gnt_idx_o` stay unchanged until `done_i` is sampled high. This holds even when other requests appear or vanish, and when `dma_low_i` changes.
- R8: When `done_i` is sampled high during a grant, `gnt_valid_o` is 0 after that edge. Pending requests are granted again on the following edge.
- R9: A reset request sampled during a non-reset grant replaces that grant with the reset grant (index 0) at the next edge, even if `done_i` is high in the same cycle.
- R10: `gnt_o` is one-hot at bit `s` of the granted source, and `gnt_idx_o` is that source's rank. When nothing is granted, `gnt_o` and `gnt_idx_o` are zero.
- R11: A `done_i` pulse while no grant is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 15 | Level-sensitive request per source (bit order as in R2 to R5) |
| dma_low_i | input | 2 | Per DMA channel: 1 selects the low priority slot |
| done_i | input | 1 | Service-complete strobe from the controller |
| gnt_o | output | 15 | One-hot grant, indexed by source |
| gnt_valid_o | output | 1 | A grant is outstanding |
| gnt_idx_o | output | 5 | Effective rank of the granted source, 0 to 16 |

## Verification
The hardest situation to reach is a change of ranking while a grant is held. It needs a low-ranked grant to be outstanding while a higher request and a DMA mode flip arrive together. The ordinary grant-and-release pattern never produces this. The stimulus therefore parks a grant on the lowest-ranked source, then raises a bus error and toggles both mode bits for several cycles before releasing it. A second directed case raises a reset request over a held USB grant. Random request sets under random modes, each released before the next, cover the ordering.

// File: rtl/svc_req_sched.sv
module svc_req_sched #(
  localparam int NSRC  = 15,
  localparam int NRANK = NSRC + 2,
  localparam int IW    = $clog2(NRANK),
  localparam int SW    = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [1:0]      dma_low_i,
  input  logic            done_i,
  output logic [NSRC-1:0] gnt_o,
  output logic            gnt_valid_o,
  output logic [IW-1:0]   gnt_idx_o
);

  logic            busy_q;
  logic [NSRC-1:0] gnt_q;
  logic [IW-1:0]   idx_q;
  logic [NRANK-1:0] rank_req;
  logic [IW-1:0]   win_idx;
  logic [SW-1:0]   win_src;
  wire             win_any = |rank_req;

  always_comb begin
    rank_req         = '0;
    rank_req[2:0]    = req_i[2:0];
    rank_req[3]      = req_i[3] & ~dma_low_i[0];
    rank_req[4]      = req_i[4] & ~dma_low_i[1];
    rank_req[10:5]   = req_i[10:5];
    rank_req[11]     = req_i[3] & dma_low_i[0];
    rank_req[12]     = req_i[4] & dma_low_i[1];
    rank_req[16:13]  = req_i[14:11];
  end

  always_comb begin
    win_idx = '0;
    for (int r = NRANK - 1; r >= 0; r--)
      if (rank_req[r]) win_idx = IW'(r);
  end

  always_comb begin
    unique case (win_idx)
      5'd11:   win_src = SW'(3);
      5'd12:   win_src = SW'(4);
      5'd13, 5'd14, 5'd15, 5'd16:
               win_src = SW'(win_idx - 5'd2);
      default: win_src = SW'(win_idx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (req_i[0] && idx_q != '0) begin
        gnt_q <= NSRC'(1);
        idx_q <= '0;
      end else if (done_i) begin
        busy_q <= 1'b0;
        gnt_q  <= '0;
        idx_q  <= '0;
      end
    end else if (win_any) begin
      busy_q <= 1'b1;
      gnt_q  <= NSRC'(1) << win_src;
      idx_q  <= win_idx;
    end
  end

  assign gnt_o       = gnt_q;
  assign gnt_valid_o = busy_q;
  assign gnt_idx_o   = idx_q;

endmodule

module svc_req_sched_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [14:0] req_i,
  input logic        done_i,
  input logic [14:0] gnt_o,
  input logic        gnt_valid_o,
  input logic [4:0]  gnt_idx_o
);

  // R10
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != '0)));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid_o |-> (gnt_idx_o == '0 && gnt_o == '0));

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !done_i && !req_i[0]) |=> ($stable(gnt_o) && $stable(gnt_idx_o)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && done_i && !req_i[0]) |=> !gnt_valid_o);

  // R9
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && req_i[0]) |=> (gnt_o[0] && gnt_idx_o == '0));

  // R2
  reset_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && req_i[0]) |=> (gnt_o[0] && gnt_idx_o == '0));

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && req_i == '0) |=> !gnt_valid_o);

endmodule

bind svc_req_sched svc_req_sched_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
  .gnt_o(gnt_o), .gnt_valid_o(gnt_valid_o), .gnt_idx_o(gnt_idx_o)
);

// File: tb/svc_req_sched_tb.sv
`timescale 1ns/1ps
module svc_req_sched_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] req_i = '0;
  logic [1:0]  dma_low_i = '0;
  logic        done_i = 1'b0;
  logic [14:0] gnt_o;
  logic        gnt_valid_o;
  logic [4:0]  gnt_idx_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  svc_req_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .dma_low_i(dma_low_i),
    .done_i(done_i), .gnt_o(gnt_o), .gnt_valid_o(gnt_valid_o),
    .gnt_idx_o(gnt_idx_o)
  );

  function automatic int ref_rank(logic [14:0] r, logic [1:0] m);
    if (r[0]) return 0;
    if (r[1]) return 1;
    if (r[2]) return 2;
    if (r[3] && !m[0]) return 3;
    if (r[4] && !m[1]) return 4;
    for (int s = 5; s <= 10; s++) if (r[s]) return s;
    if (r[3] && m[0]) return 11;
    if (r[4] && m[1]) return 12;
    for (int s = 11; s <= 14; s++) if (r[s]) return s + 2;
    return -1;
  endfunction

  function automatic int ref_src(int rank);
    if (rank == 11) return 3;
    if (rank == 12) return 4;
    if (rank >= 13) return rank - 2;
    return rank;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_grant(string tag, int rank);
    if (rank < 0) begin
      check({tag, " valid"}, 32'(gnt_valid_o), 0);
      check({tag, " gnt"}, 32'(gnt_o), 0);
      check({tag, " idx"}, 32'(gnt_idx_o), 0);
    end else begin
      check({tag, " valid"}, 32'(gnt_valid_o), 1);
      check({tag, " gnt"}, 32'(gnt_o), 32'(15'(1) << ref_src(rank)));
      check({tag, " idx"}, 32'(gnt_idx_o), 32'(rank));
    end
  endtask

  task automatic release_grant(string tag);
    req_i  = '0;
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    check({tag, " R8 release"}, 32'(gnt_valid_o), 0);
  endtask

  task automatic issue(string tag, logic [14:0] r, logic [1:0] m);
    req_i     = r;
    dma_low_i = m;
    step();
    expect_grant(tag, ref_rank(r, m));
    release_grant(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h0c0ffee5));
    @(negedge clk);
    step();
    expect_grant("R1 in reset", -1);
    rst_n = 1'b1;
    step();
    expect_grant("R1 after reset", -1);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 15; s++)
        issue("R4 R5 R10 single", 15'(1) << s, 2'(m));

    issue("R2 reset wins", 15'h7fff, 2'b00);
    issue("R3 buserr over host", 15'h7ffe, 2'b11);
    issue("R5 dma1 low vs smcA", 15'h0808, 2'b01);
    issue("R5 dma1 high vs smcA", 15'h0808, 2'b00);
    issue("R5 dma2 low vs sccB tx", 15'h0410, 2'b10);
    issue("R6 smcB rx over tx", 15'h6000, 2'b00);
    issue("R6 usb rx over tx", 15'h0060, 2'b00);

    for (int i = 0; i < 400; i++)
      issue("R4 R5 R6 random", 15'($urandom), 2'($urandom));

    // R11: done while idle
    req_i = '0;
    done_i = 1'b1;
    step();
    step();
    done_i = 1'b0;
    expect_grant("R11 idle done", -1);

    // R7 hold under new requests and mode flips, then R8 regrant
    req_i = 15'h4000;
    dma_low_i = 2'b00;
    step();
    expect_grant("R7 start", 16);
    req_i = 15'h401a;
    for (int k = 0; k < 3; k++) begin
      dma_low_i = ~dma_low_i;
      step();
      expect_grant("R7 held", 16);
    end
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    check("R8 gap", 32'(gnt_valid_o), 0);
    step();
    expect_grant("R8 regrant", 1);
    release_grant("R8 end");

    // R9 preempt, also with done in the same cycle
    req_i = 15'h0020;
    step();
    expect_grant("R9 start", 5);
    req_i = 15'h0021;
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    expect_grant("R9 preempt", 0);
    release_grant("R9 end");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule